// File: doc/BRIEF.md
# Serial Memory Write-Protection Unit

This block sits beside the command front end of a 128K x 8 serial nonvolatile memory. It owns the status register and decides, in the same cycle as each request, whether a write may go ahead. Two block-protect bits pick one of four protected regions: none, the upper quarter, the upper half, or the whole array. A lock-enable bit works together with the active-low write-protect pin to freeze the whole status register. Every write also needs the write-enable latch to be set.

The front end presents a decoded write-status request with its data byte, or an array write request with its 17-bit address. It also sends set and clear pulses for the write-enable latch. The internal write engine drives a busy flag. The unit answers each request with exactly one of grant or deny. It also supplies the byte that a read-status command returns.

The block-protect and lock-enable bits stand for nonvolatile cells. Reset loads them from parameters, which model the values held in the cells at power-up. Clearing the write-enable latch never changes them.

Top module: `serial_wp_unit`

## Requirements
- R1: When busy is low, the status byte is {lock-enable, 3'b000, BP1, BP0, write-enable latch, 1'b0}, with bit 7 the most significant.
- R2: While busy is high, the status byte reads 8'hFF.
- R3: The protection level BP1:BP0 sets the protected array range. 00 protects nothing. 01 protects 0x18000-0x1FFFF. 10 protects 0x10000-0x1FFFF. 11 protects 0x00000-0x1FFFF.
- R4: An array request is granted in its own cycle only if all of these hold: the latch is set, busy is low, the address is unprotected, and no status request is present. Otherwise it is denied. Each request raises exactly one of grant or deny, and neither is raised when no request is present.
- R5: The hardware lock is active exactly when the write-protect pin is low and lock-enable is 1. While it is active, every status write is denied, including one that would clear lock-enable.
- R6: A granted status write stores data bits 7, 3 and 2 as lock-enable, BP1 and BP0, visible from the next cycle. Data bits 0, 1 and 4 to 6 have no effect.
- R7: A granted write of either kind clears the write-enable latch in the next cycle. A denied write leaves the latch unchanged.
- R8: A set pulse sets the latch. A clear pulse or a grant in the same cycle overrides the set pulse.
- R9: Reset clears the latch and loads BP1, BP0 and lock-enable from parameters (default all 0). A clear pulse leaves those three bits unchanged.
- R10: With the write-protect pin high, or with lock-enable at 0, a status write with the latch set and busy low is granted.
- R11: When a status request and an array request arrive in the same cycle, the status request is served and the array request is denied.
- R12: While busy is high, every status and array request is denied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wel_set | input | 1 | Pulse that sets the write-enable latch |
| wel_clr | input | 1 | Pulse that clears the write-enable latch |
| sr_req | input | 1 | Decoded write-status request |
| sr_data | input | 8 | Data byte of the write-status request |
| arr_req | input | 1 | Pending array write request |
| arr_addr | input | 17 | Target byte address of the array write |
| busy | input | 1 | Internal write cycle in progress |
| wp_n | input | 1 | Write-protect pin, active low |
| status_byte | output | 8 | Byte returned by a read-status command |
| arr_grant | output | 1 | Array write allowed |
| arr_deny | output | 1 | Array write refused |
| sr_grant | output | 1 | Status write allowed |
| sr_deny | output | 1 | Status write refused |

## Verification
The hardest case to reach is a denied attempt to clear lock-enable while the pin is held low. To get there, a prior status write must have set lock-enable with the pin high, and the latch must then be set again before the pin drops. The stimulus table chains its rows so that each row inherits the stored bits and latch state left by the row before it. This puts the unit in that locked state, and later rows walk it back out through the pin. The boundaries at 0x0FFFF/0x10000 and 0x17FFF/0x18000 are each placed directly under the level that makes them matter.

// File: rtl/wp_pkg.sv
`timescale 1ns/1ps
package wp_pkg;

  typedef enum logic [1:0] {
    LVL_NONE = 2'b00,
    LVL_QTR  = 2'b01,
    LVL_HALF = 2'b10,
    LVL_ALL  = 2'b11
  } prot_lvl_e;

  typedef struct packed {
    logic      lock_en;
    prot_lvl_e lvl;
  } nv_bits_t;

  // Decide protection from the two most significant address bits.
  function automatic logic region_hit(prot_lvl_e lvl, logic [1:0] top2);
    logic hit;
    case (lvl)
      LVL_NONE: hit = 1'b0;
      LVL_QTR:  hit = (top2 == 2'b11);
      LVL_HALF: hit = top2[1];
      default:  hit = 1'b1;
    endcase
    return hit;
  endfunction

  // Read-status byte assembly.
  function automatic logic [7:0] pack_status(logic busy, logic wel, nv_bits_t nv);
    logic [7:0] s;
    if (busy) s = 8'hFF;
    else      s = {nv.lock_en, 3'b000, nv.lvl, wel, 1'b0};
    return s;
  endfunction

endpackage

// File: rtl/wp_region_dec.sv
`timescale 1ns/1ps
module wp_region_dec
  import wp_pkg::*;
(
  input  prot_lvl_e  lvl,
  input  logic [1:0] addr_top,
  output logic       hit
);
  always_comb hit = region_hit(lvl, addr_top);
endmodule

// File: rtl/wp_arbiter.sv
`timescale 1ns/1ps
module wp_arbiter (
  input  logic wel,
  input  logic busy,
  input  logic hw_lock,
  input  logic arr_prot,
  input  logic sr_req,
  input  logic arr_req,
  output logic sr_grant,
  output logic sr_deny,
  output logic arr_grant,
  output logic arr_deny
);
  logic sr_ok;
  logic arr_ok;

  always_comb begin
    sr_ok     = wel & ~busy & ~hw_lock;
    arr_ok    = wel & ~busy & ~arr_prot & ~sr_req;
    sr_grant  = sr_req & sr_ok;
    sr_deny   = sr_req & ~sr_ok;
    arr_grant = arr_req & arr_ok;
    arr_deny  = arr_req & ~arr_ok;
  end
endmodule

// File: rtl/wp_state.sv
`timescale 1ns/1ps
module wp_state
  import wp_pkg::*;
#(
  parameter logic [1:0] INIT_LVL  = 2'b00,
  parameter logic       INIT_LOCK = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wel_set,
  input  logic     wel_clr,
  input  logic     sr_commit,
  input  logic     arr_commit,
  input  nv_bits_t nv_new,
  output logic     wel,
  output nv_bits_t nv
);
  localparam nv_bits_t NV_RESET = '{lock_en: INIT_LOCK, lvl: prot_lvl_e'(INIT_LVL)};

  logic drop_wel;
  always_comb drop_wel = wel_clr | sr_commit | arr_commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel <= 1'b0;
    end else if (drop_wel) begin
      wel <= 1'b0;
    end else if (wel_set) begin
      wel <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv <= NV_RESET;
    end else if (sr_commit) begin
      nv <= nv_new;
    end
  end
endmodule

// File: rtl/serial_wp_unit.sv
`timescale 1ns/1ps
module serial_wp_unit
  import wp_pkg::*;
#(
  parameter int         ADDR_W    = 17,
  parameter logic [1:0] INIT_LVL  = 2'b00,
  parameter logic       INIT_LOCK = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wel_set,
  input  logic              wel_clr,
  input  logic              sr_req,
  input  logic [7:0]        sr_data,
  input  logic              arr_req,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic              busy,
  input  logic              wp_n,
  output logic [7:0]        status_byte,
  output logic              arr_grant,
  output logic              arr_deny,
  output logic              sr_grant,
  output logic              sr_deny
);
  localparam int TOP_LSB = ADDR_W - 2;

  // Named internal events
  logic      wel;
  nv_bits_t  nv;
  nv_bits_t  nv_new;
  logic      lock_en;
  prot_lvl_e prot_lvl;
  logic      hw_lock;
  logic      arr_prot;

  always_comb begin
    lock_en        = nv.lock_en;
    prot_lvl       = nv.lvl;
    hw_lock        = ~wp_n & lock_en;
    nv_new.lock_en = sr_data[7];
    nv_new.lvl     = prot_lvl_e'(sr_data[3:2]);
  end

  wp_region_dec u_dec (
    .lvl      (prot_lvl),
    .addr_top (arr_addr[ADDR_W-1:TOP_LSB]),
    .hit      (arr_prot)
  );

  wp_arbiter u_arb (
    .wel       (wel),
    .busy      (busy),
    .hw_lock   (hw_lock),
    .arr_prot  (arr_prot),
    .sr_req    (sr_req),
    .arr_req   (arr_req),
    .sr_grant  (sr_grant),
    .sr_deny   (sr_deny),
    .arr_grant (arr_grant),
    .arr_deny  (arr_deny)
  );

  wp_state #(
    .INIT_LVL  (INIT_LVL),
    .INIT_LOCK (INIT_LOCK)
  ) u_state (
    .clk        (clk),
    .rst_n      (rst_n),
    .wel_set    (wel_set),
    .wel_clr    (wel_clr),
    .sr_commit  (sr_grant),
    .arr_commit (arr_grant),
    .nv_new     (nv_new),
    .wel        (wel),
    .nv         (nv)
  );

  always_comb status_byte = pack_status(busy, wel, nv);
endmodule

// File: rtl/wp_unit_chk.sv
`timescale 1ns/1ps
module wp_unit_chk
  import wp_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sr_req,
  input logic [7:0]        sr_data,
  input logic              arr_req,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              busy,
  input logic [7:0]        status_byte,
  input logic              arr_grant,
  input logic              arr_deny,
  input logic              sr_grant,
  input logic              sr_deny,
  input logic              hw_lock,
  input logic              wel,
  input logic              lock_en,
  input prot_lvl_e         prot_lvl
);
  localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;

  // Lowest protected address, computed arithmetically
  logic [ADDR_W:0] limit;
  always_comb begin
    case (prot_lvl)
      LVL_NONE: limit = DEPTH;
      LVL_QTR:  limit = DEPTH - (DEPTH >> 2);
      LVL_HALF: limit = DEPTH >> 1;
      default:  limit = '0;
    endcase
  end

  // R1
  idle_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (status_byte[6:4] == 3'b000 && status_byte[0] == 1'b0 && status_byte[1] == wel));

  // R2
  busy_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> status_byte == 8'hFF);

  // R3
  arr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant |-> ({1'b0, arr_addr} < limit));

  // R4
  arr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({arr_grant, arr_deny}) && (arr_req == (arr_grant | arr_deny)));

  // R4
  sr_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sr_grant, sr_deny}) && (sr_req == (sr_grant | sr_deny)));

  // R5
  lock_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_lock && sr_req) |-> sr_deny);

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> lock_en);

  // R6
  sr_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_grant |=> (busy || ({status_byte[7], 3'b000, status_byte[3:2], 2'b00} == ($past(sr_data) & 8'h8C))));

  // R7
  wel_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_grant || arr_grant) |=> !wel);

  // R7
  need_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wel |-> (!sr_grant && !arr_grant));

  // R11
  both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sr_req && arr_req) |-> !arr_grant);

  // R12
  busy_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!sr_grant && !arr_grant));
endmodule

bind serial_wp_unit wp_unit_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/serial_wp_unit_test.sv
`timescale 1ns/1ps
module serial_wp_unit_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wel_set = 1'b0;
  logic        wel_clr = 1'b0;
  logic        sr_req = 1'b0;
  logic [7:0]  sr_data = 8'h00;
  logic        arr_req = 1'b0;
  logic [16:0] arr_addr = '0;
  logic        busy = 1'b0;
  logic        wp_n = 1'b1;
  logic [7:0]  status_byte;
  logic        arr_grant, arr_deny, sr_grant, sr_deny;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  serial_wp_unit uut (
    .clk(clk), .rst_n(rst_n), .wel_set(wel_set), .wel_clr(wel_clr),
    .sr_req(sr_req), .sr_data(sr_data), .arr_req(arr_req), .arr_addr(arr_addr),
    .busy(busy), .wp_n(wp_n), .status_byte(status_byte),
    .arr_grant(arr_grant), .arr_deny(arr_deny), .sr_grant(sr_grant), .sr_deny(sr_deny)
  );

  typedef struct packed {
    logic        wen;
    logic        pin;
    logic        bsy;
    logic        sreq;
    logic [7:0]  sdat;
    logic        areq;
    logic [16:0] addr;
    logic        exp_sg;
    logic        exp_ag;
    logic [7:0]  exp_st;
  } vec_t;

  // Rows chain: each inherits stored bits and latch from the previous one.
  localparam vec_t VECS [16] = '{
    '{1'b0,1'b1,1'b0,1'b0,8'h00,1'b1,17'h00000,1'b0,1'b0,8'h00}, // R4 no latch
    '{1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,17'h1FFFF,1'b0,1'b1,8'h00}, // R3 lvl 00, R7
    '{1'b1,1'b1,1'b0,1'b1,8'hFF,1'b0,17'h00000,1'b1,1'b0,8'h8C}, // R6 only 7,3,2 kept
    '{1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,17'h00000,1'b0,1'b0,8'h8E}, // R3 lvl 11, R7 latch kept
    '{1'b0,1'b0,1'b0,1'b1,8'h00,1'b0,17'h00000,1'b0,1'b0,8'h8E}, // R5 lock blocks clear
    '{1'b0,1'b0,1'b0,1'b0,8'h00,1'b1,17'h00000,1'b0,1'b0,8'h8E}, // R3 locked array
    '{1'b0,1'b1,1'b0,1'b1,8'h08,1'b0,17'h00000,1'b1,1'b0,8'h08}, // R10 pin high
    '{1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,17'h0FFFF,1'b0,1'b1,8'h08}, // R3 lvl 10 below
    '{1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,17'h10000,1'b0,1'b0,8'h0A}, // R3 lvl 10 edge
    '{1'b0,1'b1,1'b0,1'b1,8'h04,1'b0,17'h00000,1'b1,1'b0,8'h04}, // R6 lvl 01
    '{1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,17'h17FFF,1'b0,1'b1,8'h04}, // R3 lvl 01 below
    '{1'b1,1'b1,1'b0,1'b0,8'h00,1'b1,17'h18000,1'b0,1'b0,8'h06}, // R3 lvl 01 edge
    '{1'b0,1'b1,1'b1,1'b0,8'h00,1'b1,17'h00000,1'b0,1'b0,8'h06}, // R12 busy
    '{1'b0,1'b0,1'b0,1'b1,8'h80,1'b0,17'h00000,1'b1,1'b0,8'h80}, // R10 lock-enable 0
    '{1'b1,1'b0,1'b0,1'b1,8'h04,1'b0,17'h00000,1'b0,1'b0,8'h82}, // R5 locked
    '{1'b0,1'b1,1'b0,1'b1,8'h00,1'b1,17'h00000,1'b1,1'b0,8'h00}  // R11 both
  };

  task automatic chk(input string what, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    wel_set = 0; wel_clr = 0; sr_req = 0; sr_data = 8'h00;
    arr_req = 0; arr_addr = '0; busy = 0; wp_n = 1;
  endtask

  task automatic pulse_set();
    @(negedge clk); wel_set = 1;
    @(negedge clk); wel_set = 0;
  endtask

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R9 reset state
    chk("R9 reset status", status_byte, 8'h00);
    chk("R4 idle outputs", {4'h0, arr_grant, arr_deny, sr_grant, sr_deny}, 8'h00);
    @(negedge clk); rst_n = 1;

    for (int i = 0; i < 16; i++) begin
      if (VECS[i].wen) pulse_set();
      @(negedge clk);
      wp_n = VECS[i].pin; busy = VECS[i].bsy;
      sr_req = VECS[i].sreq; sr_data = VECS[i].sdat;
      arr_req = VECS[i].areq; arr_addr = VECS[i].addr;
      #2;
      chk($sformatf("R4/R5 row %0d grants", i),
          {4'h0, arr_grant, arr_deny, sr_grant, sr_deny},
          {4'h0, VECS[i].exp_ag, VECS[i].areq & ~VECS[i].exp_ag,
                 VECS[i].exp_sg, VECS[i].sreq & ~VECS[i].exp_sg});
      @(negedge clk);
      idle_inputs();
      #2;
      chk($sformatf("R1/R6 row %0d status", i), status_byte, 8'h00 | VECS[i].exp_st);
    end

    // R2 and R12: busy overrides status and denies writes
    pulse_set();
    @(negedge clk); busy = 1; sr_req = 1; sr_data = 8'h0C; #2;
    chk("R2 busy status", status_byte, 8'hFF);
    chk("R12 busy sr deny", {6'h0, sr_grant, sr_deny}, 8'h01);
    @(negedge clk); idle_inputs(); #2;
    chk("R12 busy left state", status_byte, 8'h02);

    // R9: latch clear keeps nonvolatile bits
    @(negedge clk); sr_req = 1; sr_data = 8'h0C; #2;
    chk("R10 grant", {7'h0, sr_grant}, 8'h01);
    @(negedge clk); idle_inputs();
    pulse_set(); #2;
    chk("R1 latch visible", status_byte, 8'h0E);
    @(negedge clk); wel_clr = 1;
    @(negedge clk); wel_clr = 0; #2;
    chk("R9 clear keeps bits", status_byte, 8'h0C);

    // R8: clear beats set
    @(negedge clk); wel_set = 1; wel_clr = 1;
    @(negedge clk); idle_inputs(); #2;
    chk("R8 clear over set", status_byte, 8'h0C);

    // R8: grant beats a set in the same cycle
    pulse_set();
    @(negedge clk); wel_set = 1; sr_req = 1; sr_data = 8'h73; #2;
    chk("R6 grant ignored bits", {7'h0, sr_grant}, 8'h01);
    @(negedge clk); idle_inputs(); #2;
    chk("R8 grant over set", status_byte, 8'h00);

    // R9: reset reloads initial nonvolatile values and clears latch
    pulse_set();
    @(negedge clk); sr_req = 1; sr_data = 8'h88;
    @(negedge clk); idle_inputs();
    pulse_set(); #2;
    chk("R6 stored before reset", status_byte, 8'h8A);
    @(negedge clk); rst_n = 0; #2;
    chk("R9 reset reload", status_byte, 8'h00);
    @(negedge clk); rst_n = 1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule